// File: doc/BRIEF.md
# Two-Page Serial Presence Detect Slave

This block is the target side of a two-wire management bus, modelling the serial presence detect store of a memory module. It holds 512 bytes arranged as two pages of 256. A host reads it with the standard byte-data transfer: a write phase that sets a one-byte offset, a repeated START with the read bit, and one or more returned bytes. A module answers at a fixed base address plus a 3-bit slot strap, so up to eight modules can share one bus.

An eight-bit offset cannot reach 512 bytes on its own. Page selection therefore goes through two extra bus addresses. Addressing the first for write selects the lower page, and addressing the second for write selects the upper page. Every module on the bus answers these two addresses, whatever its strap, so a single select reaches all modules at once. The selected page stays in force until the other select address is written. The store is filled through a byte-wide load port. After reset it reads 0xFF everywhere, except for the memory-type byte.

SCL and SDA are oversampled by the system clock. The block drives SDA only by pulling it low through `sda_oe_o`, and the surrounding pad logic supplies the open-drain wiring.

Top module: `spd_paged_slave`

## Requirements
- R1: The data address is DATA_BASE (default 7'h50) plus `slot_i`. An address byte whose upper seven bits equal it is acknowledged by pulling SDA low in the ninth clock. Any other address that is not a page-select address with the write bit is left unacknowledged.
- R2: An address byte 0x6C (7-bit 0x36, write bit 0) is acknowledged and selects page 0. An address byte 0x6E (7-bit 0x37, write bit 0) is acknowledged and selects page 1. Both are acknowledged whatever the value of `slot_i`.
- R3: Offset N on page 0 returns stored byte N. Offset N on page 1 returns stored byte 0x100+N.
- R4: The selected page is kept across any number of later reads and STOP conditions, and changes only when a page-select address is written.
- R5: A byte-data read works as follows. The address is sent with bit 0 = 0, then an offset byte that is acknowledged. Then comes a repeated START, the address with bit 0 = 1 (acknowledged), and the returned byte, shifted MSB first.
- R6: While the master acknowledges, further bytes follow from offset+1. The offset wraps from 0xFF to 0x00 within the current page.
- R7: After reset the page is 0 and SDA is released. Every byte reads 0xFF except byte 2, which reads TYPE_CODE (default 0x0C).
- R8: A cycle with `load_en_i` high writes `load_data_i` into the byte at 9-bit address `load_addr_i`, where bit 8 is the page.
- R9: After the master's NACK the block releases SDA. A STOP returns it to idle, and it changes SDA only while SCL is low.
- R10: The page-select addresses with the read bit (0x6D, 0x6F) are not acknowledged and leave the page unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_i | input | 3 | Slot strap added to the data base address |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe_o | output | 1 | High to pull SDA low |
| load_en_i | input | 1 | Store write strobe |
| load_addr_i | input | 9 | Store byte address, bit 8 selects the page |
| load_data_i | input | 8 | Byte to store |

## Verification
On every cycle, the assertions check four things. SDA drive changes only while SCL is low. The page moves only right after an address byte. A STOP forces idle with SDA released. Each further byte of a sequential read advances the offset by exactly one, modulo 256. Only the bench scenarios can show the data path: that a read returns the byte from the right page and offset, that the page persists across transfers and slot changes, that the wrap stays inside the page, and that foreign addresses and read-direction selects go unanswered.

// File: rtl/spd_pkg.sv
package spd_pkg;
    localparam logic [6:0] SEL_LO_ADDR = 7'h36;
    localparam logic [6:0] SEL_HI_ADDR = 7'h37;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_SEL_ACK,
        ST_OFFS,
        ST_OFFS_ACK,
        ST_TX,
        ST_TX_ACK
    } slv_state_e;

    typedef struct packed {
        slv_state_e st;
        logic [3:0] cnt;
        logic [7:0] sh;
        logic [7:0] tx;
        logic [7:0] offs;
        logic       page;
        logic       rw;
        logic       mack;
        logic       oe;
    } slv_ctl_t;
endpackage

// File: rtl/spd_pin_sync.sv
module spd_pin_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    // [0],[1]: two-flop synchroniser, [2]: previous synchronised value
    logic [2:0] scl_d, scl_q, sda_d, sda_q;

    always_comb begin
        scl_d = {scl_q[1:0], scl_i};
        sda_d = {sda_q[1:0], sda_i};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_q <= 3'b111;
            sda_q <= 3'b111;
        end else begin
            scl_q <= scl_d;
            sda_q <= sda_d;
        end
    end

    assign scl_lvl   = scl_q[1];
    assign sda_lvl   = sda_q[1];
    assign scl_rise  = scl_q[1] & ~scl_q[2];
    assign scl_fall  = ~scl_q[1] & scl_q[2];
    assign start_det = scl_q[1] & scl_q[2] & ~sda_q[1] & sda_q[2];
    assign stop_det  = scl_q[1] & scl_q[2] & sda_q[1] & ~sda_q[2];
endmodule

// File: rtl/spd_store.sv
module spd_store #(
    parameter int         PAGES      = 2,
    parameter int         PAGE_BYTES = 256,
    parameter logic [7:0] TYPE_CODE  = 8'h0C,
    parameter int         TYPE_IDX   = 2,
    localparam int        DEPTH      = PAGES * PAGE_BYTES,
    localparam int        AW         = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] mem_q [DEPTH];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++)
                mem_q[i] <= (i == TYPE_IDX) ? TYPE_CODE : 8'hFF;
        end else if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/spd_paged_slave.sv
module spd_paged_slave
    import spd_pkg::*;
#(
    parameter logic [6:0] DATA_BASE = 7'h50,
    parameter logic [7:0] TYPE_CODE = 8'h0C,
    parameter int         PAGES     = 2,
    localparam int        AW        = $clog2(PAGES * 256)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [2:0]    slot_i,
    input  logic          scl_i,
    input  logic          sda_i,
    output logic          sda_oe_o,
    input  logic          load_en_i,
    input  logic [AW-1:0] load_addr_i,
    input  logic [7:0]    load_data_i
);
    logic scl_lvl, sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic [7:0] rd_byte;
    logic [7:0] in_byte;
    logic [6:0] my_addr;
    slv_ctl_t   d, q;

    spd_pin_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_i    (scl_i),
        .sda_i    (sda_i),
        .scl_lvl  (scl_lvl),
        .sda_lvl  (sda_lvl),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    spd_store #(
        .PAGES     (PAGES),
        .PAGE_BYTES(256),
        .TYPE_CODE (TYPE_CODE),
        .TYPE_IDX  (2)
    ) u_store (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (load_en_i),
        .wr_addr(load_addr_i),
        .wr_data(load_data_i),
        .rd_addr(AW'({q.page, q.offs})),
        .rd_data(rd_byte)
    );

    assign in_byte = {q.sh[6:0], sda_lvl};
    assign my_addr = DATA_BASE + {4'd0, slot_i};

    always_comb begin
        d = q;
        if (stop_det) begin
            d.st = ST_IDLE;
            d.oe = 1'b0;
        end else if (start_det) begin
            d.st  = ST_ADDR;
            d.cnt = 4'd0;
            d.oe  = 1'b0;
        end else begin
            unique case (q.st)
                ST_IDLE: ;
                ST_ADDR, ST_OFFS: begin
                    if (scl_rise) begin
                        d.sh  = in_byte;
                        d.cnt = q.cnt + 4'd1;
                        if (q.cnt == 4'd7) begin
                            d.cnt = 4'd0;
                            if (q.st == ST_OFFS) begin
                                d.offs = in_byte;
                                d.st   = ST_OFFS_ACK;
                            end else if (in_byte[7:1] == my_addr) begin
                                d.rw = in_byte[0];
                                d.st = ST_ADDR_ACK;
                            end else if (!in_byte[0] && in_byte[7:1] == SEL_LO_ADDR) begin
                                d.page = 1'b0;
                                d.st   = ST_SEL_ACK;
                            end else if (!in_byte[0] && in_byte[7:1] == SEL_HI_ADDR) begin
                                d.page = 1'b1;
                                d.st   = ST_SEL_ACK;
                            end else begin
                                d.st = ST_IDLE;
                            end
                        end
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        if (!q.oe) begin
                            d.oe = 1'b1;
                        end else if (q.rw) begin
                            d.tx   = rd_byte;
                            d.offs = q.offs + 8'd1;
                            d.oe   = ~rd_byte[7];
                            d.cnt  = 4'd0;
                            d.st   = ST_TX;
                        end else begin
                            d.oe  = 1'b0;
                            d.cnt = 4'd0;
                            d.st  = ST_OFFS;
                        end
                    end
                end
                ST_SEL_ACK, ST_OFFS_ACK: begin
                    if (scl_fall) begin
                        d.oe = ~q.oe;
                        if (q.oe) d.st = ST_IDLE;
                    end
                end
                ST_TX: begin
                    if (scl_rise) begin
                        d.cnt = q.cnt + 4'd1;
                    end else if (scl_fall) begin
                        if (q.cnt == 4'd8) begin
                            d.oe  = 1'b0;
                            d.cnt = 4'd0;
                            d.st  = ST_TX_ACK;
                        end else begin
                            d.tx = {q.tx[6:0], 1'b1};
                            d.oe = ~q.tx[6];
                        end
                    end
                end
                ST_TX_ACK: begin
                    if (scl_rise) begin
                        d.mack = ~sda_lvl;
                    end else if (scl_fall) begin
                        if (q.mack) begin
                            d.tx   = rd_byte;
                            d.offs = q.offs + 8'd1;
                            d.oe   = ~rd_byte[7];
                            d.st   = ST_TX;
                        end else begin
                            d.oe = 1'b0;
                            d.st = ST_IDLE;
                        end
                    end
                end
                default: d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, cnt: 4'd0, sh: 8'd0, tx: 8'hFF, offs: 8'd0,
                   page: 1'b0, rw: 1'b0, mack: 1'b0, oe: 1'b0};
        end else begin
            q <= d;
        end
    end

    assign sda_oe_o = q.oe;

    // R9: SDA drive moves only while the synchronised SCL is low
    p_sda_moves_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (q.oe != $past(q.oe)) |-> !scl_lvl);

    // R9: a STOP leaves the slave idle with SDA released
    p_stop_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (q.st == ST_IDLE && !q.oe));

    // R4: page register moves only right after an address byte
    p_page_on_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.page != $past(q.page)) |-> ($past(q.st) == ST_ADDR));

    // R6: each further byte of a sequential read steps the offset by one, mod 256
    p_offs_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(q.st) == ST_TX_ACK && q.st == ST_TX) |-> (q.offs == 8'($past(q.offs) + 8'd1)));

    // R1: SDA is never driven while idle
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_IDLE) |-> !q.oe);
endmodule

// File: tb/sim_spd_paged_slave.sv
module sim_spd_paged_slave;
    localparam int Q = 10;

    typedef struct {
        logic [7:0] v;
        string      tag;
    } item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] slot = 3'd5;
    logic       m_scl = 1'b1;
    logic       m_sda = 1'b1;
    logic       load_en = 1'b0;
    logic [8:0] load_addr = '0;
    logic [7:0] load_data = '0;
    logic       sda_oe;
    wire        sda_line = m_sda & ~sda_oe;

    logic [7:0] model [512];
    logic       page_m = 1'b0;
    item_t      exp_q[$];
    item_t      act_q[$];
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 1'b0;

    always #2 clk = ~clk;

    spd_paged_slave u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .slot_i     (slot),
        .scl_i      (m_scl),
        .sda_i      (sda_line),
        .sda_oe_o   (sda_oe),
        .load_en_i  (load_en),
        .load_addr_i(load_addr),
        .load_data_i(load_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic qw();
        repeat (Q) @(negedge clk);
    endtask

    task automatic bus_start();
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
        m_sda = 1'b0; qw(); m_scl = 1'b0; qw();
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; qw(); m_scl = 1'b1; qw(); m_sda = 1'b1; qw();
    endtask

    task automatic put_byte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0;
        end
        qw();
        m_sda = 1'b1; qw(); m_scl = 1'b1; qw();
        ack = ~sda_line;
        qw(); m_scl = 1'b0; qw();
    endtask

    task automatic get_byte(input logic give_ack, input string tag);
        item_t it;
        m_sda = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            qw(); m_scl = 1'b1; qw();
            it.v[i] = sda_line;
            qw(); m_scl = 1'b0;
        end
        it.tag = tag;
        act_q.push_back(it);
        qw();
        m_sda = ~give_ack; qw(); m_scl = 1'b1; qw(); qw(); m_scl = 1'b0; qw();
        m_sda = 1'b1;
    endtask

    task automatic load(input logic [8:0] a, input logic [7:0] v);
        @(negedge clk);
        load_en = 1'b1; load_addr = a; load_data = v;
        @(negedge clk);
        load_en = 1'b0;
        model[a] = v;
    endtask

    task automatic select(input logic [7:0] abyte, input logic exp_ack, input string tag);
        logic ack;
        bus_start();
        put_byte(abyte, ack);
        check(ack == exp_ack, tag, ack, exp_ack);
        bus_stop();
        if (exp_ack) page_m = abyte[1];
    endtask

    task automatic read_seq(input logic [6:0] a, input logic [7:0] offs, input int n, input string tag);
        logic ack;
        item_t it;
        bus_start();
        put_byte({a, 1'b0}, ack);
        check(ack, {tag, " R1 address ack"}, ack, 1);
        put_byte(offs, ack);
        check(ack, {tag, " R5 offset ack"}, ack, 1);
        bus_start();
        put_byte({a, 1'b1}, ack);
        check(ack, {tag, " R5 read ack"}, ack, 1);
        for (int i = 0; i < n; i++) begin
            it.v = model[{page_m, 8'(offs + 8'(i))}];
            it.tag = tag;
            exp_q.push_back(it);
            get_byte(i < n - 1, tag);
        end
        check(sda_line == 1'b1, "R9 SDA released after NACK", sda_line, 1);
        bus_stop();
    endtask

    task automatic probe_nack(input logic [7:0] abyte, input string tag);
        logic ack;
        bus_start();
        put_byte(abyte, ack);
        check(!ack, tag, ack, 0);
        bus_stop();
    endtask

    // scoreboard monitor
    initial begin
        item_t a, e;
        forever begin
            @(negedge clk);
            if (act_q.size() > 0) begin
                a = act_q.pop_front();
                if (exp_q.size() > 0) begin
                    e = exp_q.pop_front();
                    check(a.v == e.v, e.tag, a.v, e.v);
                end else begin
                    check(1'b0, {a.tag, " unexpected byte"}, a.v, 0);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_vec++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 512; i++) model[i] = 8'hFF;
        model[2] = 8'h0C;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        check(sda_line == 1'b1, "R7 SDA released after reset", sda_line, 1);

        // R7: type byte and blank byte from reset contents
        read_seq(7'h55, 8'h02, 1, "R7 type code");
        read_seq(7'h55, 8'h80, 1, "R7 blank reads 0xFF");

        // R8: fill both pages through the load port
        load(9'h000, 8'h11); load(9'h001, 8'h22); load(9'h0FF, 8'hA5);
        load(9'h100, 8'h5A); load(9'h110, 8'h3C); load(9'h1FE, 8'h81);
        load(9'h1FF, 8'h7E);
        read_seq(7'h55, 8'h00, 2, "R8 R3 page0 loaded bytes");

        // R1: foreign data address is not acknowledged
        probe_nack({7'h50, 1'b0}, "R1 foreign address nack");

        // R2: select upper page, then read it
        select({7'h37, 1'b0}, 1'b1, "R2 upper select ack");
        read_seq(7'h55, 8'h00, 1, "R3 page1 offset 0");
        read_seq(7'h55, 8'h10, 1, "R4 page kept across reads");

        // R6: sequential read wraps within page 1
        read_seq(7'h55, 8'hFE, 3, "R6 sequential wrap page1");

        // R10: read-direction select neither acks nor changes page
        probe_nack({7'h36, 1'b1}, "R10 read-bit select nack");
        read_seq(7'h55, 8'h00, 1, "R10 page still 1");

        // R2: select acknowledged with another slot strap, back to page 0
        slot = 3'd2;
        select({7'h36, 1'b0}, 1'b1, "R2 lower select ack other slot");
        read_seq(7'h52, 8'hFF, 1, "R3 page0 top byte new slot");
        probe_nack({7'h55, 1'b0}, "R1 old slot address nack");

        // R9: after STOP a fresh read works
        read_seq(7'h52, 8'h01, 1, "R9 read after stop");

        repeat (40) @(negedge clk);
        check(exp_q.size() == 0, "R5 all expected bytes returned", exp_q.size(), 0);
        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule